// File: doc/BRIEF.md
# Serial Host Control Port

This block is the slave end of a five-wire serial link. A host processor uses it to set the configuration of a line interface and to collect its alarm state. The host pulls chip select low and clocks one sixteen-bit frame. The frame has a direction bit, a seven-bit register address and one data byte. The block oversamples the serial lines with its own system clock. It decodes the frame and either commits the byte to a small register file or shifts the addressed register back out on the serial data output.

The register file has several configuration bytes that leave the block as plain outputs. It also has a per-source interrupt enable byte, a global interrupt enable and an alarm status byte. A status bit latches every change of its alarm input, rising or falling, and the bit clears when the host reads it. A read-only identifier byte completes the map. The active-low interrupt pin is asserted while the global enable is on and at least one enabled status bit is set. The reset pin acts asynchronously, is released synchronously and returns every register to its default value.

Register map (7-bit addresses): 0x00 source interrupt enables, 0x01 to 0x01+NCTRL-1 configuration bytes, 0x20 global interrupt enable (bit 0), 0x21 alarm status (bit i follows alarm input i), 0x3E identifier. Every other address is reserved.

Top module: `ser_ctrl_port`

## Requirements
- R1: A frame is sampled on rising serial-clock edges while chip select is low, MSB first. It is one direction bit (1 = read, 0 = write), then 7 address bits, then 8 data bits. A write takes effect once the sixteenth bit has been sampled.
- R2: In a read frame, the addressed byte appears on the serial data output starting with bit 7. The first bit is driven on the falling edge after the last address bit, and each later bit on the next falling edge.
- R3: The serial data output enable is high only during the data bits of a read frame. It is low between frames, during write frames and during address bits.
- R4: If chip select rises before the sixteenth bit of a write frame, no register changes.
- R5: The configuration bytes at 0x01 onward and the enable bytes at 0x00 and 0x20 can be written and read back. Each configuration byte drives its own byte of the configuration output, with address 0x01 on the lowest byte.
- R6: Address 0x3E reads the fixed identifier, 0x5A by default, and writes to it have no effect.
- R7: Reserved addresses read 0x00, and writes to them have no effect. The status address 0x21 also ignores writes.
- R8: Status bit i at 0x21 becomes 1 whenever alarm input i changes level in either direction.
- R9: A read of 0x21 returns the status and then clears the bits it returned. A change that arrives in the same cycle stays set.
- R10: The interrupt output is low exactly when bit 0 of 0x20 is 1 and some status bit is set whose enable bit at 0x00 is also 1. Otherwise it is high.
- R11: While reset is low, the configuration outputs are at their default value (zero), the enables and status are cleared, the interrupt output is high and the data output is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low register reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo_data | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | Output enable for the serial data pad; low means high impedance |
| irq_n | output | 1 | Active-low interrupt request |
| alarm | input | NSRC | Alarm conditions whose changes are latched into status |
| ctrl_out | output | NCTRL*8 | Configuration bytes, address 0x01 in the low byte |

## Verification
The bench goes after the cases where decoding is off by one bit. If the direction bit were taken from the wrong position, or a shift were off by one, the readback of a patterned byte would come back rotated or would be a different register. A write cut short after twelve bits would still change the register if the commit were not held back to the sixteenth edge. Reading the status twice shows whether clear-on-read works: a missing clear gives a second nonzero read and an interrupt that never goes away, and a falling alarm that is not latched gives a zero read. With the global enable off, or the source enable off, a wrong gating term would pull the interrupt low.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;

  localparam int FRAME_BITS = 16;
  localparam int HDR_BITS   = 8;

  localparam logic [6:0] ADDR_SRC_EN    = 7'h00;
  localparam logic [6:0] ADDR_CTRL_BASE = 7'h01;
  localparam logic [6:0] ADDR_GIE       = 7'h20;
  localparam logic [6:0] ADDR_STATUS    = 7'h21;
  localparam logic [6:0] ADDR_DEV_ID    = 7'h3E;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= {W{RST_VAL}};
        end else begin
          if (s == 0) stg_q[s] <= d;
          else        stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/ser_frame.sv
module ser_frame
  import ser_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_s,
  input  logic       cs_n_s,
  input  logic       sdi_s,
  input  logic [7:0] rd_data,
  output logic       cs_act,
  output logic       rd_stb,
  output logic [6:0] rd_addr,
  output logic       wr_stb,
  output logic [6:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sdo_data,
  output logic       sdo_oe
);

  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST_HDR  = CW'(HDR_BITS - 1);
  localparam logic [CW-1:0] FIRST_DAT = CW'(HDR_BITS);
  localparam logic [CW-1:0] LAST_BIT  = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] DONE      = CW'(FRAME_BITS);

  logic          sclk_d_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [6:0]    sh_q, sh_n;
  dir_e          dir_q, dir_n;
  logic [6:0]    addr_q, addr_n;
  logic [7:0]    out_q, out_n;
  logic          sdo_q, sdo_n;
  logic          oe_q, oe_n;
  logic          rise, fall;

  assign cs_act = ~cs_n_s;
  assign rise   = sclk_s & ~sclk_d_q;
  assign fall   = ~sclk_s & sclk_d_q;

  always_comb begin
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    dir_n   = dir_q;
    addr_n  = addr_q;
    out_n   = out_q;
    sdo_n   = sdo_q;
    oe_n    = oe_q;
    rd_stb  = 1'b0;
    wr_stb  = 1'b0;
    rd_addr = {sh_q[5:0], sdi_s};
    wr_addr = addr_q;
    wr_data = {sh_q, sdi_s};
    if (!cs_act) begin
      cnt_n = '0;
      oe_n  = 1'b0;
      dir_n = DIR_WRITE;
    end else begin
      if (rise && (cnt_q < DONE)) begin
        sh_n  = {sh_q[5:0], sdi_s};
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == LAST_HDR) begin
          dir_n  = dir_e'(sh_q[6]);
          addr_n = {sh_q[5:0], sdi_s};
          if (dir_e'(sh_q[6]) == DIR_READ) begin
            rd_stb = 1'b1;
            out_n  = rd_data;
          end
        end
        if ((cnt_q == LAST_BIT) && (dir_q == DIR_WRITE)) begin
          wr_stb = 1'b1;
        end
      end
      if (fall) begin
        if ((dir_q == DIR_READ) && (cnt_q >= FIRST_DAT) && (cnt_q < DONE)) begin
          sdo_n = out_q[7];
          out_n = {out_q[6:0], 1'b0};
          oe_n  = 1'b1;
        end else begin
          oe_n  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      dir_q    <= DIR_WRITE;
      addr_q   <= '0;
      out_q    <= '0;
      sdo_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
      dir_q    <= dir_n;
      addr_q   <= addr_n;
      out_q    <= out_n;
      sdo_q    <= sdo_n;
      oe_q     <= oe_n;
    end
  end

  assign sdo_data = sdo_q;
  assign sdo_oe   = oe_q;

endmodule

// File: rtl/ser_regs.sv
module ser_regs
  import ser_ctrl_pkg::*;
#(
  parameter int               NSRC     = 4,
  parameter int               NCTRL    = 4,
  parameter logic [7:0]       DEV_ID   = 8'h5A,
  parameter logic [NCTRL*8-1:0] CTRL_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [6:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [6:0]         rd_addr,
  input  logic [NSRC-1:0]    status,
  output logic [7:0]         rd_data,
  output logic [NSRC-1:0]    src_en,
  output logic               gie,
  output logic [NCTRL*8-1:0] ctrl_flat
);

  logic [NSRC-1:0] src_en_q;
  logic            gie_q;
  logic            src_we, gie_we;

  assign src_we = wr_stb && (wr_addr == ADDR_SRC_EN);
  assign gie_we = wr_stb && (wr_addr == ADDR_GIE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en_q <= '0;
      gie_q    <= 1'b0;
    end else begin
      if (src_we) src_en_q <= wr_data[NSRC-1:0];
      if (gie_we) gie_q    <= wr_data[0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCTRL; g++) begin : g_ctrl
      localparam logic [6:0] A = ADDR_CTRL_BASE + 7'(g);
      logic [7:0] byte_q;
      logic       we;
      assign we = wr_stb && (wr_addr == A);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  byte_q <= CTRL_RST[g*8 +: 8];
        else if (we) byte_q <= wr_data;
      end
      assign ctrl_flat[g*8 +: 8] = byte_q;
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    case (rd_addr)
      ADDR_SRC_EN: rd_data[NSRC-1:0] = src_en_q;
      ADDR_GIE:    rd_data[0]        = gie_q;
      ADDR_STATUS: rd_data[NSRC-1:0] = status;
      ADDR_DEV_ID: rd_data           = DEV_ID;
      default: begin
        for (int i = 0; i < NCTRL; i++) begin
          if (rd_addr == ADDR_CTRL_BASE + 7'(i)) rd_data = ctrl_flat[i*8 +: 8];
        end
      end
    endcase
  end

  assign src_en = src_en_q;
  assign gie    = gie_q;

endmodule

// File: rtl/ser_irq.sv
module ser_irq #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] alarm_s,
  input  logic            clr_stb,
  input  logic [NSRC-1:0] src_en,
  input  logic            gie,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] chg,
  output logic            irq_n
);

  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] stat_q, stat_n;
  logic            irq_q, irq_nx;

  assign chg = alarm_s ^ prev_q;

  always_comb begin
    stat_n = stat_q;
    if (clr_stb) stat_n = '0;
    stat_n = stat_n | chg;
    irq_nx = ~(gie & |(stat_q & src_en));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b1;
    end else begin
      prev_q <= alarm_s;
      stat_q <= stat_n;
      irq_q  <= irq_nx;
    end
  end

  assign status = stat_q;
  assign irq_n  = irq_q;

endmodule

// File: rtl/ser_ctrl_port.sv
module ser_ctrl_port
  import ser_ctrl_pkg::*;
#(
  parameter int                 NSRC        = 4,
  parameter int                 NCTRL       = 4,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [7:0]         DEV_ID      = 8'h5A,
  parameter logic [NCTRL*8-1:0] CTRL_RST    = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  output logic               sdo_data,
  output logic               sdo_oe,
  output logic               irq_n,
  input  logic [NSRC-1:0]    alarm,
  output logic [NCTRL*8-1:0] ctrl_out
);

  logic [1:0]      rst_sh_q;
  logic            rst_i;
  logic            sclk_s, cs_n_s, sdi_s;
  logic [NSRC-1:0] alarm_s;
  logic            cs_act, rd_stb, wr_stb;
  logic [6:0]      rd_addr, wr_addr;
  logic [7:0]      wr_data, rd_data;
  logic [NSRC-1:0] status, chg, src_en;
  logic            gie, clr_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_i = rst_sh_q[1];

  ser_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_lo (
    .clk(clk), .rst_n(rst_i), .d({sclk, sdi}), .q({sclk_s, sdi_s})
  );
  ser_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_i), .d(cs_n), .q(cs_n_s)
  );
  ser_sync #(.W(NSRC), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_alm (
    .clk(clk), .rst_n(rst_i), .d(alarm), .q(alarm_s)
  );

  ser_frame u_frame (
    .clk(clk), .rst_n(rst_i), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .cs_act(cs_act), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo_data(sdo_data), .sdo_oe(sdo_oe)
  );

  ser_regs #(.NSRC(NSRC), .NCTRL(NCTRL), .DEV_ID(DEV_ID), .CTRL_RST(CTRL_RST)) u_regs (
    .clk(clk), .rst_n(rst_i), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .status(status), .rd_data(rd_data), .src_en(src_en),
    .gie(gie), .ctrl_flat(ctrl_out)
  );

  assign clr_stb = rd_stb && (rd_addr == ADDR_STATUS);

  ser_irq #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_i), .alarm_s(alarm_s), .clr_stb(clr_stb),
    .src_en(src_en), .gie(gie), .status(status), .chg(chg), .irq_n(irq_n)
  );

endmodule

// File: rtl/ser_ctrl_port_chk.sv
module ser_ctrl_port_chk #(
  parameter int NSRC  = 4,
  parameter int NCTRL = 4
) (
  input logic               clk,
  input logic               rst_i,
  input logic               cs_act,
  input logic               wr_stb,
  input logic [NSRC-1:0]    chg,
  input logic [NSRC-1:0]    status,
  input logic [NSRC-1:0]    src_en,
  input logic               gie,
  input logic               irq_n,
  input logic               sdo_oe,
  input logic [NCTRL*8-1:0] ctrl_out
);

  assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_i)
    !gie |=> irq_n);

  assert_irq_on_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (gie && |(status & src_en)) |=> !irq_n);

  assert_change_latched_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (|chg) |=> ((status & $past(chg)) == $past(chg)));

  assert_sdo_float_R3: assert property (@(posedge clk) disable iff (!rst_i)
    !cs_act |=> !sdo_oe);

  assert_write_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_i)
    wr_stb |-> cs_act);

  assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_i)
    !wr_stb |=> $stable(ctrl_out));

endmodule

bind ser_ctrl_port ser_ctrl_port_chk #(.NSRC(NSRC), .NCTRL(NCTRL)) u_chk (
  .clk(clk), .rst_i(rst_i), .cs_act(cs_act), .wr_stb(wr_stb), .chg(chg),
  .status(status), .src_en(src_en), .gie(gie), .irq_n(irq_n),
  .sdo_oe(sdo_oe), .ctrl_out(ctrl_out)
);

// File: tb/ser_ctrl_port_bench.sv
module ser_ctrl_port_bench;

  localparam int NSRC  = 4;
  localparam int NCTRL = 4;
  localparam int HALF  = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b1;
  logic               cs_n = 1'b1;
  logic               sclk = 1'b0;
  logic               sdi = 1'b0;
  logic               sdo_data, sdo_oe, irq_n;
  logic [NSRC-1:0]    alarm = '0;
  logic [NCTRL*8-1:0] ctrl_out;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  ser_ctrl_port #(.NSRC(NSRC), .NCTRL(NCTRL)) u_ser_ctrl_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo_data(sdo_data), .sdo_oe(sdo_oe), .irq_n(irq_n),
    .alarm(alarm), .ctrl_out(ctrl_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input bit rd, input logic [6:0] addr, input logic [7:0] data, input int nbits);
    logic [15:0] bits;
    bits = {rd, addr, data};
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = bits[15-i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2*HALF);
  endtask

  task automatic wr(input logic [6:0] addr, input logic [7:0] data);
    frame(1'b0, addr, data, 16);
  endtask

  task automatic rd(input logic [6:0] addr, input logic [7:0] exp, input string tag);
    exp_t e;
    e.val = exp;
    e.tag = tag;
    exp_q.push_back(e);
    frame(1'b1, addr, 8'h00, 16);
  endtask

  // Monitor: follows the bench-driven frame, collects read data, compares against the queue.
  initial begin
    int         idx;
    logic       dir;
    logic [7:0] got;
    logic       oe_bad;
    exp_t       e;
    idx = 0; dir = 1'b0; got = '0; oe_bad = 1'b0;
    forever begin
      @(posedge sclk or posedge cs_n);
      if (cs_n) begin
        idx = 0;
      end else begin
        if (idx == 0) begin
          dir = sdi;
          oe_bad = 1'b0;
        end else if (idx < 8) begin
          if (sdo_oe) oe_bad = 1'b1;
        end else if (idx < 16) begin
          if (dir) begin
            got[15-idx] = sdo_data;
            if (!sdo_oe) oe_bad = 1'b1;
          end else if (sdo_oe) begin
            oe_bad = 1'b1;
          end
          if (idx == 15) begin
            chk(!oe_bad, "R3 output enable window", {31'd0, oe_bad}, 32'd0);
            if (dir) begin
              if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected read", {24'd0, got}, 32'd0);
              end else begin
                e = exp_q.pop_front();
                chk(got == e.val, e.tag, {24'd0, got}, {24'd0, e.val});
              end
            end
          end
        end
        idx++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R11 reset state
    chk(irq_n == 1'b1, "R11 irq idle after reset", {31'd0, irq_n}, 32'd1);
    chk(sdo_oe == 1'b0, "R11 sdo disabled after reset", {31'd0, sdo_oe}, 32'd0);
    chk(ctrl_out == '0, "R11 ctrl default", ctrl_out, 32'd0);

    // R1 R5 write and readback of configuration bytes
    wr(7'h01, 8'hA3);
    wr(7'h04, 8'h3C);
    chk(ctrl_out[7:0] == 8'hA3, "R5 ctrl byte 0", {24'd0, ctrl_out[7:0]}, 32'hA3);
    chk(ctrl_out[31:24] == 8'h3C, "R5 ctrl byte 3", {24'd0, ctrl_out[31:24]}, 32'h3C);
    rd(7'h01, 8'hA3, "R1 R2 readback 0x01");
    rd(7'h04, 8'h3C, "R2 readback 0x04");

    // R6 identifier
    rd(7'h3E, 8'h5A, "R6 id read");
    wr(7'h3E, 8'hFF);
    rd(7'h3E, 8'h5A, "R6 id after write");

    // R7 reserved
    wr(7'h10, 8'h77);
    rd(7'h10, 8'h00, "R7 reserved after write");
    rd(7'h7F, 8'h00, "R7 reserved 0x7F");

    // R4 aborted write
    frame(1'b0, 7'h02, 8'h99, 12);
    chk(ctrl_out[15:8] == 8'h00, "R4 aborted write", {24'd0, ctrl_out[15:8]}, 32'h00);
    rd(7'h02, 8'h00, "R4 readback after abort");
    wr(7'h02, 8'hC8);
    chk(ctrl_out[15:8] == 8'hC8, "R1 full write after abort", {24'd0, ctrl_out[15:8]}, 32'hC8);

    // R8 R9 R10 status and interrupt
    wr(7'h00, 8'h0F);
    wr(7'h20, 8'h01);
    rd(7'h21, 8'h00, "R7 status idle");
    alarm[1] = 1'b1;
    wait_clk(10);
    chk(irq_n == 1'b0, "R10 irq asserted", {31'd0, irq_n}, 32'd0);
    wr(7'h21, 8'h00);
    chk(irq_n == 1'b0, "R7 status ignores write", {31'd0, irq_n}, 32'd0);
    rd(7'h21, 8'h02, "R8 rising alarm latched");
    chk(irq_n == 1'b1, "R9 irq released after read", {31'd0, irq_n}, 32'd1);
    rd(7'h21, 8'h00, "R9 status cleared by read");
    alarm[1] = 1'b0;
    wait_clk(10);
    rd(7'h21, 8'h02, "R8 falling alarm latched");

    // R10 global enable gating
    wr(7'h20, 8'h00);
    alarm[2] = 1'b1;
    wait_clk(10);
    chk(irq_n == 1'b1, "R10 global enable off", {31'd0, irq_n}, 32'd1);
    wr(7'h20, 8'h01);
    chk(irq_n == 1'b0, "R10 global enable on", {31'd0, irq_n}, 32'd0);
    rd(7'h21, 8'h04, "R9 status read alarm 2");

    // R10 source enable gating
    wr(7'h00, 8'h01);
    alarm[3] = 1'b1;
    wait_clk(10);
    chk(irq_n == 1'b1, "R10 source enable off", {31'd0, irq_n}, 32'd1);
    rd(7'h21, 8'h08, "R8 status alarm 3");
    rd(7'h20, 8'h01, "R5 global enable readback");
    rd(7'h00, 8'h01, "R5 source enable readback");

    // R11 asynchronous reset
    alarm = '0;
    wait_clk(10);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk(ctrl_out == '0, "R11 async ctrl clear", ctrl_out, 32'd0);
    chk(irq_n == 1'b1, "R11 async irq high", {31'd0, irq_n}, 32'd1);
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(5);
    rd(7'h20, 8'h00, "R11 global enable default");
    rd(7'h00, 8'h00, "R11 source enable default");
    rd(7'h21, 8'h00, "R11 status default");
    rd(7'h02, 8'h00, "R11 ctrl default readback");

    wait_clk(20);
    chk(exp_q.size() == 0, "R2 all reads observed", exp_q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule